// File: doc/BRIEF.md
# Video acquisition window timing generator

This block follows one interlaced video channel at pixel rate and raises a capture-enable window over the active acquisition area of each field. It counts pixels from a horizontal reference edge and lines from an accepted vertical sync edge. It reports the pixel and line position inside the window and flags whether the current field is the first or the second field. A pixel-rate enable paces all counting, so the block runs from a faster system clock.

The horizontal reference is either the burstkey pulse or the horizontal sync pulse. Using horizontal sync adds a fixed delay to the horizontal start. Two 4-bit fine-position values shift the window: the horizontal one in steps of `H_STEP` pixels, the vertical one in steps of one line. These values and the reference choice are captured only at an accepted vertical sync edge, so the window shape never changes inside a field.

A vertical sync edge that arrives while the current field's window is still open is discarded. This keeps the window intact for non-standard signals. The field flag comes from the field-ID input at the accepted edge, and a polarity bit can invert it.

Top module: `acq_window_gen`

## Requirements
- R1: The window is `ACT_W` pixels wide and `ACT_H` lines high. Inside it, `pix_cnt` runs 0..`ACT_W`-1 along a line and `line_cnt` runs 0..`ACT_H`-1 down the field. Both read 0 whenever `cap_en` is low.
- R2: The pixel index is 0 on the pixel where the selected reference rises, and it rises by 1 per enabled pixel. With burstkey as the reference (`ref_is_hsync`=0), the window opens at pixel index `H_BASE` + `H_STEP`*`hfine`.
- R3: With horizontal sync as the reference (`ref_is_hsync`=1), the horizontal start is delayed by a further `HSYNC_DLY` pixels. The other reference input then has no effect.
- R4: The line index is 0 on the line that holds the accepted vertical sync rising edge. It rises by 1 at each rising edge of the selected horizontal reference. The window covers line indices `V_BASE`+`vfine` up to `V_BASE`+`vfine`+`ACT_H`-1.
- R5: At an accepted vertical sync rising edge, `second_field` is set to `field_id` XOR `field_pol`. With `field_pol`=0, `field_id`=0 gives the first field (0) and 1 gives the second field (1). The flag keeps that value until the next accepted edge.
- R6: `hfine`, `vfine` and `ref_is_hsync` are sampled only at an accepted vertical sync edge. Changes at any other time have no effect on the window of the current field.
- R7: A vertical sync rising edge that arrives while the line index is inside the current window is ignored. The line count does not restart, the field flag does not change, and no fine-position value is sampled.
- R8: Inputs are sampled only on cycles with `pix_en` high. The outputs for a sampled pixel appear one clock later and hold through cycles with `pix_en` low.
- R9: After reset, all outputs are 0 and no window opens until the first vertical sync edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-rate enable |
| hsync_in | input | 1 | Horizontal sync pulse, rising edge active |
| burst_in | input | 1 | Burstkey pulse, rising edge active |
| vsync_in | input | 1 | Vertical sync pulse, rising edge active |
| field_id | input | 1 | Field-ID reference level sampled at vertical sync |
| field_pol | input | 1 | Inverts the field classification |
| ref_is_hsync | input | 1 | 1: horizontal sync is the reference; 0: burstkey |
| hfine | input | 4 | Horizontal fine position |
| vfine | input | 4 | Vertical fine position |
| cap_en | output | 1 | Capture window active |
| pix_cnt | output | $clog2(ACT_W) | Pixel position inside the window |
| line_cnt | output | $clog2(ACT_H) | Line position inside the window |
| second_field | output | 1 | 1 for the second field of the frame |

## Verification
Every output is registered, so the result for a pixel sampled at one rising edge is visible after that same edge. The bench drives each pixel at a falling edge and compares the registered outputs at the next falling edge against what it predicted for that pixel. The field flag is due right after the pixel that carries the accepted vertical sync rise. When `pix_en` is low, the bench keeps its previous expectation, since the outputs must hold. Expected window positions come from the bench's own line and pixel coordinates, the chosen reference offset and the fine-position arithmetic.

// File: rtl/acqw_pkg.sv
package acqw_pkg;
  typedef struct packed {
    logic       hs_ref;
    logic [3:0] hfine;
    logic [3:0] vfine;
  } acqw_cfg_t;
endpackage

// File: rtl/acqw_edge.sv
module acqw_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ce) q <= din;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign rise[i] = din[i] & ~q[i];
    end
  endgenerate

  // R8: the history moves only on enabled pixels
  a_r8_edge_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));
endmodule

// File: rtl/acqw_hcount.sv
module acqw_hcount
  import acqw_pkg::*;
#(
  parameter int HCW       = 11,
  parameter int ACT_W     = 672,
  parameter int H_BASE    = 80,
  parameter int HSYNC_DLY = 68,
  parameter int H_STEP    = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic           ref_edge,
  input  acqw_cfg_t      cfg,
  output logic           hin,
  output logic [HCW-1:0] hofs
);
  localparam logic [HCW-1:0] HMAX = {HCW{1'b1}};

  logic [HCW-1:0] h_q, pos;
  logic [HCW:0]   hstart, hend;

  always_comb begin
    hstart = (HCW+1)'(H_BASE + (cfg.hs_ref ? HSYNC_DLY : 0) + H_STEP * int'(cfg.hfine));
    hend   = hstart + (HCW+1)'(ACT_W);
    if (ref_edge)         pos = '0;
    else if (h_q == HMAX) pos = h_q;
    else                  pos = h_q + 1'b1;
    hin  = ({1'b0, pos} >= hstart) && ({1'b0, pos} < hend);
    hofs = pos - hstart[HCW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     h_q <= HMAX;
    else if (ce) h_q <= pos;
  end

  // R2: a reference edge restarts the pixel index
  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    (ce && ref_edge) |=> (h_q == '0));
  // R2: without an edge the index never moves backwards
  a_r2_monotonic: assert property (@(posedge clk) disable iff (rst)
    (ce && !ref_edge) |=> (h_q >= $past(h_q)));
endmodule

// File: rtl/acqw_vtrack.sv
module acqw_vtrack
  import acqw_pkg::*;
#(
  parameter int VCW    = 10,
  parameter int ACT_H  = 228,
  parameter int V_BASE = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic           h_edge,
  input  logic           v_rise,
  input  logic           field_ref,
  input  logic           field_pol,
  input  acqw_cfg_t      cfg_in,
  output acqw_cfg_t      cfg_eff,
  output logic           vin,
  output logic [VCW-1:0] lofs,
  output logic           second_field
);
  localparam logic [VCW-1:0] VMAX = {VCW{1'b1}};

  logic [VCW-1:0] vl_q, line_nx, vstart_q, vend_q, vstart_e, vend_e;
  acqw_cfg_t      cfg_q;
  logic           sf_q, busy, accept;

  always_comb begin
    vstart_q = VCW'(V_BASE) + VCW'(cfg_q.vfine);
    vend_q   = vstart_q + VCW'(ACT_H);
    busy     = (vl_q >= vstart_q) && (vl_q < vend_q);
    accept   = v_rise && !busy;
    cfg_eff  = accept ? cfg_in : cfg_q;
    if (accept)                        line_nx = '0;
    else if (h_edge && vl_q != VMAX)   line_nx = vl_q + 1'b1;
    else                               line_nx = vl_q;
    vstart_e = VCW'(V_BASE) + VCW'(cfg_eff.vfine);
    vend_e   = vstart_e + VCW'(ACT_H);
    vin      = (line_nx >= vstart_e) && (line_nx < vend_e);
    lofs     = line_nx - vstart_e;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q  <= VMAX;
      cfg_q <= '0;
      sf_q  <= 1'b0;
    end else if (ce) begin
      vl_q <= line_nx;
      if (accept) begin
        cfg_q <= cfg_in;
        sf_q  <= field_ref ^ field_pol;
      end
    end
  end

  assign second_field = sf_q;

  // R6: settings change only at an accepted vertical edge
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    !(ce && accept) |=> $stable(cfg_q));
  // R5: field flag moves only at an accepted vertical edge
  a_r5_flag_frozen: assert property (@(posedge clk) disable iff (rst)
    !(ce && accept) |=> $stable(sf_q));
  // R7: an edge inside the open window does not restart the line count
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (ce && v_rise && busy) |=> (vl_q >= $past(vl_q)));
  // R4: an accepted edge starts line zero
  a_r4_line_zero: assert property (@(posedge clk) disable iff (rst)
    (ce && accept) |=> (vl_q == '0));
endmodule

// File: rtl/acq_window_gen.sv
module acq_window_gen
  import acqw_pkg::*;
#(
  parameter int ACT_W       = 672,
  parameter int ACT_H       = 228,
  parameter int LINE_PIX    = 864,
  parameter int FIELD_LINES = 263,
  parameter int H_BASE      = 80,
  parameter int HSYNC_DLY   = 68,
  parameter int H_STEP      = 2,
  parameter int V_BASE      = 18,
  localparam int PCW        = $clog2(ACT_W),
  localparam int LCW        = $clog2(ACT_H)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pix_en,
  input  logic           hsync_in,
  input  logic           burst_in,
  input  logic           vsync_in,
  input  logic           field_id,
  input  logic           field_pol,
  input  logic           ref_is_hsync,
  input  logic [3:0]     hfine,
  input  logic [3:0]     vfine,
  output logic           cap_en,
  output logic [PCW-1:0] pix_cnt,
  output logic [LCW-1:0] line_cnt,
  output logic           second_field
);
  localparam int HCW = $clog2(LINE_PIX) + 1;
  localparam int VCW = $clog2(FIELD_LINES) + 1;

  logic [2:0]     rise;
  logic           h_edge, hin, vin, win;
  logic [HCW-1:0] hofs;
  logic [VCW-1:0] lofs;
  acqw_cfg_t      cfg_live, cfg_eff;

  assign cfg_live = '{hs_ref: ref_is_hsync, hfine: hfine, vfine: vfine};

  acqw_edge #(.N(3)) u_edge (
    .clk (clk),
    .rst (rst),
    .ce  (pix_en),
    .din ({vsync_in, hsync_in, burst_in}),
    .rise(rise)
  );

  assign h_edge = cfg_eff.hs_ref ? rise[1] : rise[0];

  acqw_vtrack #(.VCW(VCW), .ACT_H(ACT_H), .V_BASE(V_BASE)) u_vtrack (
    .clk         (clk),
    .rst         (rst),
    .ce          (pix_en),
    .h_edge      (h_edge),
    .v_rise      (rise[2]),
    .field_ref   (field_id),
    .field_pol   (field_pol),
    .cfg_in      (cfg_live),
    .cfg_eff     (cfg_eff),
    .vin         (vin),
    .lofs        (lofs),
    .second_field(second_field)
  );

  acqw_hcount #(
    .HCW(HCW), .ACT_W(ACT_W), .H_BASE(H_BASE),
    .HSYNC_DLY(HSYNC_DLY), .H_STEP(H_STEP)
  ) u_hcount (
    .clk     (clk),
    .rst     (rst),
    .ce      (pix_en),
    .ref_edge(h_edge),
    .cfg     (cfg_eff),
    .hin     (hin),
    .hofs    (hofs)
  );

  assign win = hin & vin;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en   <= 1'b0;
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else if (pix_en) begin
      cap_en   <= win;
      pix_cnt  <= win ? PCW'(hofs) : '0;
      line_cnt <= win ? LCW'(lofs) : '0;
    end
  end

  // R1: the window opens at its first pixel
  a_r1_first_pix: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_en) |-> (pix_cnt == '0));
  // R1: positions read zero outside the window
  a_r1_zero_outside: assert property (@(posedge clk) disable iff (rst)
    !cap_en |-> (pix_cnt == '0 && line_cnt == '0));
  // R1: line position stays below the window height
  a_r1_line_bound: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> (int'(line_cnt) < ACT_H));
  // R8: outputs hold on idle cycles
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(cap_en) && $stable(pix_cnt) && $stable(line_cnt)));
endmodule

// File: tb/acq_window_gen_bench.sv
module acq_window_gen_bench;
  localparam int ACT_W = 8, ACT_H = 3, LINE_PIX = 64, FIELD_LINES = 20;
  localparam int H_BASE = 3, HSYNC_DLY = 5, H_STEP = 2, V_BASE = 1;
  localparam int BK_OFS = 10;   // burstkey rises at this pixel of a bench line
  localparam int VS_X   = 30;   // vertical sync rises at this pixel of line 0

  logic clk = 1'b0, rst = 1'b1;
  logic pix_en = 0, hsync_in = 0, burst_in = 0, vsync_in = 0;
  logic field_id = 0, field_pol = 0, ref_is_hsync = 0;
  logic [3:0] hfine = 0, vfine = 0;
  logic cap_en, second_field;
  logic [2:0] pix_cnt;
  logic [1:0] line_cnt;

  always #2 clk = ~clk;

  acq_window_gen #(
    .ACT_W(ACT_W), .ACT_H(ACT_H), .LINE_PIX(LINE_PIX), .FIELD_LINES(FIELD_LINES),
    .H_BASE(H_BASE), .HSYNC_DLY(HSYNC_DLY), .H_STEP(H_STEP), .V_BASE(V_BASE)
  ) u_acq_window_gen (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hsync_in(hsync_in), .burst_in(burst_in),
    .vsync_in(vsync_in), .field_id(field_id), .field_pol(field_pol),
    .ref_is_hsync(ref_is_hsync), .hfine(hfine), .vfine(vfine), .cap_en(cap_en),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .second_field(second_field)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  logic p_cap = 0, p_sf = 0;
  int p_pix = 0, p_line = 0;
  string p_req = "R9";
  logic n_hs, n_bk, n_vs, n_fr, n_fp, n_sel;
  logic [3:0] n_hf, n_vf;
  logic cur_sf = 0;

  task automatic check_out();
    n_chk++;
    if (cap_en !== p_cap || int'(pix_cnt) != p_pix || int'(line_cnt) != p_line) begin
      n_fail++;
      $display("FAIL %s: cap/pix/line actual %0b/%0d/%0d expected %0b/%0d/%0d",
               p_req, cap_en, pix_cnt, line_cnt, p_cap, p_pix, p_line);
    end
    n_chk++;
    if (second_field !== p_sf) begin
      n_fail++;
      $display("FAIL R5: second_field actual %0b expected %0b", second_field, p_sf);
    end
  endtask

  task automatic cyc(input logic en, input logic ecap, input int ep, input int el,
                     input string req);
    @(negedge clk);
    check_out();
    pix_en = en; hsync_in = n_hs; burst_in = n_bk; vsync_in = n_vs;
    field_id = n_fr; field_pol = n_fp; ref_is_hsync = n_sel;
    hfine = n_hf; vfine = n_vf;
    if (en) begin
      p_cap = ecap; p_pix = ecap ? ep : 0; p_line = ecap ? el : 0;
      p_sf = cur_sf; p_req = req;
    end
  endtask

  // one field of FIELD_LINES lines of LINE_PIX pixels
  task automatic run_field(input int hf, input int vf, input bit sel, input bit fr,
                           input bit fp, input bit extra, input bit gaps, input bit novs);
    int vs0, hs0, off;
    vs0 = V_BASE + vf;
    hs0 = H_BASE + (sel ? HSYNC_DLY : 0) + H_STEP * hf;
    off = sel ? 0 : BK_OFS;
    for (int y = 0; y < FIELD_LINES; y++) begin
      for (int x = 0; x < LINE_PIX; x++) begin
        logic ecap;
        string req;
        n_hs = (x < 2);
        n_bk = (x >= BK_OFS && x < BK_OFS + 2);
        n_vs = (!novs && y == 0 && x >= VS_X && x < VS_X + 3) ||
               (extra && y == vs0 + 1 && x >= 40 && x < 42);
        if (y == 0 && x == 0) begin
          n_hf = 4'(hf); n_vf = 4'(vf); n_sel = sel; n_fr = fr; n_fp = fp;
        end
        if (y == 5 && x == 0) begin   // R6: mid-field changes must not matter
          n_hf = ~4'(hf); n_vf = ~4'(vf); n_sel = ~sel; n_fr = ~fr; n_fp = fp;
        end
        if (extra && y == vs0 + 1 && x == 0) n_fr = ~n_fr;  // R7: ignored edge
        if (!novs && y == 0 && x == VS_X) cur_sf = fr ^ fp;
        ecap = !novs && y >= vs0 && y < vs0 + ACT_H && x >= off &&
               (x - off) >= hs0 && (x - off) < hs0 + ACT_W;
        if (novs)       req = "R9";
        else if (extra) req = "R7";
        else if (sel)   req = "R3 R4 R1";
        else            req = "R2 R4 R1 R6";
        if (gaps) cyc(1'b0, 1'b0, 0, 0, "R8");
        cyc(1'b1, ecap, x - off - hs0, y - vs0, gaps ? "R8" : req);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        done = 1;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected under 200000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    n_hs = 0; n_bk = 0; n_vs = 0; n_fr = 0; n_fp = 0; n_sel = 0; n_hf = 0; n_vf = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state, then no window without a vertical edge
    run_field(0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int f = 0; f < 16; f++)
      run_field(f, f, f[0], f[1], f[2], f[0] ^ f[3], 1'b0, 1'b0);
    for (int f = 0; f < 16; f++)
      run_field(15 - f, (f * 7) % 16, ~f[0], f[0], f[1], f[1], 1'b0, 1'b0);
    run_field(6, 2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);   // R8 idle cycles
    run_field(9, 11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check_out();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule